// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block holds received characters between a serial receiver and a processor read port. Each received character is stored with three flags from the receiver: parity error, framing error and break. The processor side sees the oldest stored character and that character's flags. It can remove the oldest character, and it can read the status, which clears the sticky overrun indication.

The block reports four things beyond the head character. It shows whether any character is waiting. It records an overrun when a character arrives with no free slot. It keeps a live summary that stays high while any stored character carries an error. It raises a trigger output once the occupancy reaches a threshold picked by a 2-bit select.

Two inputs clear the queue. A one-cycle flush pulse empties it. Holding the enable input low keeps it empty and ignores all traffic. Deserialization and baud timing belong to the receiver and are outside this block.

Top module: `rx_char_queue`

## Requirements
- R1: `rd_data` shows the oldest stored character, and characters leave in the order they arrived. `rd_data` is 0 while the queue is empty.
- R2: `data_ready` is 1 when at least one character is stored and 0 when the queue is empty. It updates on the clock edge that stores or removes a character.
- R3: A `flush` pulse empties the queue on the next edge. A write in the same cycle is discarded. The queue accepts writes again in the following cycle.
- R4: While `en` is 0, writes and pops have no effect, the queue is held empty, and `any_err` is 0.
- R5: `head_par`, `head_frm` and `head_brk` give the flags stored with the character at the head. All three are 0 while the queue is empty.
- R6: `any_err` is 1 while at least one stored character has a parity, framing or break flag. It returns to 0 once all such characters have been popped, flushed or discarded because `en` was 0.
- R7: The queue holds 16 characters by default. A write that arrives while the queue is full is dropped, even if a pop happens in the same cycle, and the stored contents stay as they were.
- R8: A dropped write sets `overrun` on the next edge. `overrun` stays 1 until a `stat_rd` cycle that has no dropped write of its own clears it. A drop in the same cycle as `stat_rd` leaves it at 1.
- R9: `trig_sel` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 entries. `trig` is 1 while the occupancy is at or above the selected threshold, and it follows a change of `trig_sel` without waiting for a clock edge.
- R10: A pop on an empty queue is ignored. A pop and a write in the same cycle on a queue that is not full both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Queue enable. When 0 the queue is held empty |
| flush | input | 1 | Single-cycle request to empty the queue |
| wr_valid | input | 1 | Receiver offers a character this cycle |
| wr_data | input | 8 | Received character |
| wr_par | input | 1 | Parity error flag for the offered character |
| wr_frm | input | 1 | Framing error flag for the offered character |
| wr_brk | input | 1 | Break flag for the offered character |
| rd_pop | input | 1 | Remove the head character |
| stat_rd | input | 1 | Status read strobe. Clears overrun |
| trig_sel | input | 2 | Trigger threshold select |
| rd_data | output | 8 | Head character |
| data_ready | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky flag for a dropped write |
| head_par | output | 1 | Parity flag of the head character |
| head_frm | output | 1 | Framing flag of the head character |
| head_brk | output | 1 | Break flag of the head character |
| any_err | output | 1 | Some stored character carries an error |
| trig | output | 1 | Occupancy is at or above the selected threshold |

## Verification
The assertions check several properties on every cycle. A flush or a low enable leaves the queue empty. A pop on an empty queue changes nothing. A write to a full queue raises overrun. The error tally never exceeds the occupancy. A full queue always drives the trigger. Other behaviour depends on a history of traffic, so only the bench scenarios show it. This covers arrival order, which flags the head presents as characters drain, when the error summary clears, overrun surviving a status read that coincides with a drop, and the exact trigger threshold for every select value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // per-character receiver flags, stored beside each data byte
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rxq_flags_t;

   localparam int FLAG_W = $bits(rxq_flags_t);

   function automatic logic flags_any(input rxq_flags_t f);
      return f.brk | f.frm | f.par;
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int ENTRY_W = 11,
   parameter int DEPTH   = 16,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               push,
   input  logic               pop,
   input  logic [ENTRY_W-1:0] din,
   output logic [ENTRY_W-1:0] dout,
   output logic [CNT_W-1:0]   count,
   output logic               full,
   output logic               empty
);

   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [ENTRY_W-1:0] slot [DEPTH];

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_store: DEPTH must be a power of two of at least 2");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && wr_ptr == PTR_W'(g))
            slot[g] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign dout  = empty ? '0 : slot[rd_ptr];

   // R3: a clear leaves nothing stored
   a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);

   // R10: no push and no pop on an empty store leaves it empty
   a_r10_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push && !clr) |=> empty);

endmodule

// File: rtl/rxq_errtally.sv
module rxq_errtally #(
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             push_err,
   input  logic             pop,
   input  logic             pop_err,
   input  logic [CNT_W-1:0] occupancy,
   output logic             any_err
);

   logic [CNT_W-1:0] err_cnt;
   logic             inc, dec;

   assign inc = push & push_err;
   assign dec = pop & pop_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_cnt <= '0;
      else if (clr)
         err_cnt <= '0;
      else if (inc && !dec)
         err_cnt <= err_cnt + 1'b1;
      else if (dec && !inc)
         err_cnt <= err_cnt - 1'b1;
   end

   assign any_err = (err_cnt != '0);

   // R6: the tally of errored entries can never exceed the stored entries
   a_r6_tally_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt <= occupancy);

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
   parameter int DEPTH  = 16,
   parameter int THR0   = 1,
   parameter int THR1   = 4,
   parameter int THR2   = 8,
   parameter int THR3   = 14,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] count,
   output logic             hit
);

   localparam int THR [4] = '{THR0, THR1, THR2, THR3};

   logic [3:0] over;

   for (genvar t = 0; t < 4; t++) begin : g_level
      if (THR[t] < 1 || THR[t] > DEPTH) begin : g_bad_thr
         $error("rxq_trigger: each threshold must lie in 1..DEPTH");
      end
      assign over[t] = (count >= CNT_W'(THR[t]));
   end

   assign hit = over[sel];

   // R9: every threshold is reached once the queue is full
   a_r9_full_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> hit);

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
   import rxq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   parameter int THR0  = 1,
   parameter int THR1  = 4,
   parameter int THR2  = 8,
   parameter int THR3  = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          flush,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_par,
   input  logic          wr_frm,
   input  logic          wr_brk,
   input  logic          rd_pop,
   input  logic          stat_rd,
   input  logic [1:0]    trig_sel,
   output logic [DW-1:0] rd_data,
   output logic          data_ready,
   output logic          overrun,
   output logic          head_par,
   output logic          head_frm,
   output logic          head_brk,
   output logic          any_err,
   output logic          trig
);

   localparam int ENTRY_W = DW + FLAG_W;
   localparam int CNT_W   = $clog2(DEPTH + 1);

   if (DW < 1) begin : g_bad_dw
      $error("rx_char_queue: DW must be positive");
   end

   rxq_flags_t         in_flags, hd_flags;
   logic [ENTRY_W-1:0] in_entry, hd_entry;
   logic [CNT_W-1:0]   count;
   logic               full, empty, clr, do_push, do_pop, dropped;

   assign in_flags = '{brk: wr_brk, frm: wr_frm, par: wr_par};
   assign in_entry = {in_flags, wr_data};

   assign clr     = flush | ~en;
   assign do_push = wr_valid & en & ~flush & ~full;
   assign do_pop  = rd_pop & en & ~flush & ~empty;
   assign dropped = wr_valid & en & ~flush & full;

   rxq_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (do_push),
      .pop   (do_pop),
      .din   (in_entry),
      .dout  (hd_entry),
      .count (count),
      .full  (full),
      .empty (empty)
   );

   assign hd_flags = rxq_flags_t'(hd_entry[ENTRY_W-1:DW]);
   assign rd_data  = hd_entry[DW-1:0];
   assign head_par = hd_flags.par;
   assign head_frm = hd_flags.frm;
   assign head_brk = hd_flags.brk;
   assign data_ready = ~empty;

   rxq_errtally #(.DEPTH(DEPTH)) u_tally (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (do_push),
      .push_err  (flags_any(in_flags)),
      .pop       (do_pop),
      .pop_err   (flags_any(hd_flags)),
      .occupancy (count),
      .any_err   (any_err)
   );

   rxq_trigger #(
      .DEPTH(DEPTH), .THR0(THR0), .THR1(THR1), .THR2(THR2), .THR3(THR3)
   ) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (trig_sel),
      .count (count),
      .hit   (trig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         overrun <= 1'b0;
      else if (dropped)
         overrun <= 1'b1;
      else if (stat_rd)
         overrun <= 1'b0;
   end

   // R8: a write offered to a full enabled queue raises overrun
   a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && en && !flush && !data_ready ? 1'b0 :
       wr_valid && en && !flush && full) |=> overrun);

   // R4: disabling leaves the queue empty and error-free
   a_r4_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!data_ready && !any_err));

   // R7: a full queue keeps its head across a dropped write
   a_r7_full_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_valid && en && !flush && !rd_pop) |=> $stable(rd_data));

endmodule

// File: tb/sim_rx_char_queue.sv
module sim_rx_char_queue;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, flush = 1'b0, wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_par = 1'b0, wr_frm = 1'b0, wr_brk = 1'b0;
   logic       rd_pop = 1'b0, stat_rd = 1'b0;
   logic [1:0] trig_sel = '0;
   logic [7:0] rd_data;
   logic       data_ready, overrun, head_par, head_frm, head_brk, any_err, trig;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_char_queue u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk),
      .rd_pop(rd_pop), .stat_rd(stat_rd), .trig_sel(trig_sel),
      .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
      .head_par(head_par), .head_frm(head_frm), .head_brk(head_brk),
      .any_err(any_err), .trig(trig)
   );

   // flags field order {brk, frm, par}
   typedef struct packed {
      logic       en, flush, wr, pop, st;
      logic [7:0] data;
      logic [2:0] flg;
      logic       x_dr, x_any, x_ov;
      logic [7:0] x_rd;
      logic [2:0] x_flg;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1,0,1,0,0, 8'hA5, 3'b000, 1,0,0, 8'hA5, 3'b000},
      '{1,0,1,0,0, 8'h3C, 3'b001, 1,1,0, 8'hA5, 3'b000},
      '{1,0,1,0,0, 8'h71, 3'b110, 1,1,0, 8'hA5, 3'b000},
      '{1,0,0,1,0, 8'h00, 3'b000, 1,1,0, 8'h3C, 3'b001},
      '{1,0,0,1,0, 8'h00, 3'b000, 1,1,0, 8'h71, 3'b110},
      '{1,0,0,1,0, 8'h00, 3'b000, 0,0,0, 8'h00, 3'b000},
      '{1,0,0,1,0, 8'h00, 3'b000, 0,0,0, 8'h00, 3'b000},
      '{1,0,1,0,0, 8'h12, 3'b100, 1,1,0, 8'h12, 3'b100},
      '{1,1,0,0,0, 8'h00, 3'b000, 0,0,0, 8'h00, 3'b000},
      '{1,1,1,0,0, 8'h44, 3'b010, 0,0,0, 8'h00, 3'b000},
      '{0,0,1,0,0, 8'h55, 3'b001, 0,0,0, 8'h00, 3'b000},
      '{1,0,1,0,0, 8'h66, 3'b001, 1,1,0, 8'h66, 3'b001},
      '{0,0,1,1,0, 8'h77, 3'b000, 0,0,0, 8'h00, 3'b000}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // apply inputs, let one rising edge pass, return at the falling edge
   task automatic cyc(input logic e, input logic f, input logic w, input logic p,
                      input logic s, input logic [7:0] d, input logic [2:0] fl);
      en = e; flush = f; wr_valid = w; rd_pop = p; stat_rd = s;
      wr_data = d; {wr_brk, wr_frm, wr_par} = fl;
      @(posedge clk);
      @(negedge clk);
      flush = 1'b0; wr_valid = 1'b0; rd_pop = 1'b0; stat_rd = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R2 reset ready", data_ready, 0);
      chk("R8 reset overrun", overrun, 0);
      chk("R6 reset any_err", any_err, 0);
      chk("R9 reset trig", trig, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1 R2 R3 R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i].en, VEC[i].flush, VEC[i].wr, VEC[i].pop, VEC[i].st,
             VEC[i].data, VEC[i].flg);
         chk($sformatf("R2 vec%0d ready", i), data_ready, VEC[i].x_dr);
         chk($sformatf("R6 vec%0d any_err", i), any_err, VEC[i].x_any);
         chk($sformatf("R8 vec%0d overrun", i), overrun, VEC[i].x_ov);
         chk($sformatf("R1 vec%0d rd_data", i), rd_data, VEC[i].x_rd);
         chk($sformatf("R5 vec%0d head flags", i),
             {head_brk, head_frm, head_par}, VEC[i].x_flg);
      end

      // R9: thresholds at every fill level, R7 capacity of 16
      cyc(1, 1, 0, 0, 0, 8'h00, 3'b000);
      for (int k = 0; k <= 16; k++) begin
         for (int s = 0; s < 4; s++) begin
            int thr;
            thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            trig_sel = 2'(s);
            #1;
            chk($sformatf("R9 sel%0d level%0d", s, k), trig, (k >= thr) ? 1 : 0);
         end
         if (k < 16) cyc(1, 0, 1, 0, 0, 8'(8'h80 + k), 3'b000);
      end

      // R7 / R8: write when full is dropped and flags overrun
      cyc(1, 0, 1, 0, 0, 8'hEE, 3'b111);
      chk("R8 overrun on drop", overrun, 1);
      chk("R7 head kept", rd_data, 8'h80);
      chk("R7 no error stored", any_err, 0);
      cyc(1, 0, 1, 0, 1, 8'hEE, 3'b000);
      chk("R8 drop beats stat_rd", overrun, 1);
      cyc(1, 0, 0, 0, 1, 8'h00, 3'b000);
      chk("R8 stat_rd clears", overrun, 0);
      cyc(1, 0, 0, 0, 0, 8'h00, 3'b000);
      chk("R8 stays clear", overrun, 0);
      // R7: pop plus write while full, write still dropped
      cyc(1, 0, 1, 1, 0, 8'hDD, 3'b000);
      chk("R7 pop beside drop", rd_data, 8'h81);
      chk("R8 drop with pop", overrun, 1);
      for (int k = 1; k < 16; k++) begin
         chk($sformatf("R1 drain order %0d", k), rd_data, 8'h80 + k);
         cyc(1, 0, 0, 1, 0, 8'h00, 3'b000);
      end
      chk("R2 drained", data_ready, 0);
      chk("R8 sticky without read", overrun, 1);

      // R10: simultaneous pop and write on non-full queue
      cyc(1, 0, 1, 0, 0, 8'h21, 3'b000);
      cyc(1, 0, 1, 1, 0, 8'h22, 3'b010);
      chk("R10 pop and write head", rd_data, 8'h22);
      chk("R10 pop and write flags", {head_brk, head_frm, head_par}, 3'b010);
      chk("R6 errored entry present", any_err, 1);
      cyc(1, 0, 0, 1, 0, 8'h00, 3'b000);
      chk("R10 single entry left", data_ready, 0);
      chk("R6 cleared after drain", any_err, 0);

      // R3: queue usable right after a flush
      cyc(1, 1, 1, 0, 0, 8'h31, 3'b000);
      cyc(1, 0, 1, 0, 0, 8'h32, 3'b000);
      chk("R3 write after flush", rd_data, 8'h32);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule